// File: doc/BRIEF.md
# Serial Register Control Port

A four-wire serial slave that lets a host processor read and write a bank of 8-bit control registers. The host selects the block by pulling the active-low select line low, toggles the serial clock, and shifts bits in most-significant bit first. The first byte of every transaction is an address byte. Its upper seven bits must equal the block's fixed device code, and its last bit gives the direction.

A write transaction sends a register pointer byte next, followed by any number of data bytes. A read transaction returns data starting at the register the pointer currently selects, so a read normally follows a write that carried only a pointer byte. The pointer steps forward after every data byte in either direction, which gives burst access to consecutive registers.

All serial pins are sampled by the block's own clock through synchronizers. The serial clock must stay well below a quarter of that clock's frequency. The data output comes with a separate enable, so the pad can be tri-stated. The register contents are presented in parallel to the logic they control.

Top module: `spi_regport`

## Requirements
- R1: After reset every register reads 0x00 on `regs_o` and `sdo_en_o` is low.
- R2: The address byte matches when its bits 7..1 equal 7'b1001111. Bit 0 is the direction (1 = read, 0 = write), so the codes are 0x9E for a write and 0x9F for a read. A non-matching address byte makes the block ignore the rest of the transaction: no register changes and `sdo_en_o` stays low.
- R3: Input data is sampled on rising serial clock edges, most-significant bit first. In a write transaction the byte after the address is the pointer, and each following byte is stored in the register the pointer selects. The stored value is visible on `regs_o`, where register i occupies bits [8i+7:8i].
- R4: After each written data byte the pointer advances by one, and it wraps from register 15 to register 0.
- R5: A pointer byte with a value of 16 or more selects register 0.
- R6: In a read transaction, the falling serial clock edge that ends the address byte drives the MSB of the selected register on `sdo_o` and raises `sdo_en_o`. Each later falling edge shifts out the next bit.
- R7: After each byte read the pointer advances by one, with the same wrap as R4. A read starts at the pointer left by the previous transaction, including a write that carried only a pointer byte.
- R8: `sdo_en_o` is high only while read data is being driven. It is low during write transactions and low between transactions.
- R9: Deasserting the select line ends the transaction at any bit. A partly received data byte is discarded, and the next transaction starts aligned at bit 7 of a new address byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cs_ni | input | 1 | Serial select, active low |
| sclk_i | input | 1 | Serial clock from the host |
| sdi_i | input | 1 | Serial data from the host |
| sdo_o | output | 1 | Serial data to the host |
| sdo_en_o | output | 1 | Output enable for the `sdo_o` pad |
| regs_o | output | 128 | Register bank contents, register i at bits [8i+7:8i] |

## Verification
The hardest state to reach from the pins is a select deassertion in the middle of a data byte that follows a valid pointer byte. The pointer has been updated at that point, but the data register must not change. The stimulus drives four bits of a data byte and then raises the select line. It then checks that the target register is unchanged and reads it back, which confirms that the pointer survived the abort. A following write confirms that the bit alignment recovered. A second corner case is the pointer wrap, which is reached by a three-byte burst starting at register 14 and by a pointer-only write to register 15 followed by a two-byte read.

// File: rtl/spi_regport_pkg.sv
package spi_regport_pkg;
  typedef enum logic [2:0] {
    PH_ADDR  = 3'd0,
    PH_PTR   = 3'd1,
    PH_WDATA = 3'd2,
    PH_READ  = 3'd3,
    PH_SKIP  = 3'd4
  } phase_e;
endpackage

// File: rtl/spi_regport_sync.sv
module spi_regport_sync #(
  parameter int         W       = 1,
  parameter int         STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stage_q[s] <= RST_VAL;
      else if (s == 0) stage_q[s] <= d_i;
      else stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/spi_regport_regfile.sv
module spi_regport_regfile #(
  parameter int NUM_REGS = 16,
  parameter int DW       = 8,
  localparam int PW      = $clog2(NUM_REGS)
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   wr_en_i,
  input  logic [PW-1:0]          wr_addr_i,
  input  logic [DW-1:0]          wr_data_i,
  input  logic [PW-1:0]          rd_addr_i,
  output logic [DW-1:0]          rd_data_o,
  output logic [NUM_REGS*DW-1:0] regs_o
);
  logic [DW-1:0] mem_q [NUM_REGS];

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) mem_q[i] <= '0;
      else if (wr_en_i && (wr_addr_i == PW'(i))) mem_q[i] <= wr_data_i;
    end
    assign regs_o[i*DW +: DW] = mem_q[i];
  end

  assign rd_data_o = mem_q[rd_addr_i];
endmodule

// File: rtl/spi_regport_frame.sv
module spi_regport_frame
  import spi_regport_pkg::*;
#(
  parameter int            NUM_REGS = 16,
  parameter int            DW       = 8,
  parameter logic [DW-2:0] CHIP_ID  = 7'b1001111,
  localparam int           PW       = $clog2(NUM_REGS),
  localparam int           BW       = $clog2(DW)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cs_s_i,
  input  logic          sclk_s_i,
  input  logic          sdi_s_i,
  input  logic [DW-1:0] rd_data_i,
  output logic          wr_en_o,
  output logic [DW-1:0] wr_data_o,
  output logic [PW-1:0] ptr_o,
  output logic          sclk_fall_o,
  output logic          in_read_o,
  output logic          sdo_o,
  output logic          sdo_en_o
);
  localparam logic [DW:0] NREG_W = (DW+1)'(NUM_REGS);

  phase_e        phase_q;
  logic          sclk_prev_q;
  logic [BW-1:0] bit_cnt_q, out_cnt_q;
  logic [DW-2:0] in_sr_q;
  logic [DW-1:0] out_sr_q;
  logic [PW-1:0] ptr_q, ptr_inc;
  logic          rise, fall, byte_done;
  logic [DW-1:0] byte_w;

  assign rise      = sclk_s_i & ~sclk_prev_q;
  assign fall      = ~sclk_s_i & sclk_prev_q;
  assign byte_done = rise & (bit_cnt_q == BW'(DW-1));
  assign byte_w    = {in_sr_q, sdi_s_i};
  assign ptr_inc   = (ptr_q == PW'(NUM_REGS-1)) ? '0 : ptr_q + 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sclk_prev_q <= 1'b0;
    else         sclk_prev_q <= sclk_s_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q   <= PH_ADDR;
      bit_cnt_q <= '0;
      out_cnt_q <= '0;
      in_sr_q   <= '0;
      out_sr_q  <= '0;
      ptr_q     <= '0;
      sdo_o     <= 1'b0;
      sdo_en_o  <= 1'b0;
    end else if (cs_s_i) begin
      phase_q   <= PH_ADDR;
      bit_cnt_q <= '0;
      out_cnt_q <= '0;
      sdo_en_o  <= 1'b0;
    end else begin
      if (rise) begin
        in_sr_q   <= byte_w[DW-2:0];
        bit_cnt_q <= bit_cnt_q + 1'b1;
      end
      if (byte_done) begin
        unique case (phase_q)
          PH_ADDR: begin
            if (byte_w[DW-1:1] != CHIP_ID) phase_q <= PH_SKIP;
            else if (byte_w[0])            phase_q <= PH_READ;
            else                           phase_q <= PH_PTR;
          end
          PH_PTR: begin
            ptr_q   <= ({1'b0, byte_w} < NREG_W) ? byte_w[PW-1:0] : '0;
            phase_q <= PH_WDATA;
          end
          PH_WDATA, PH_READ: ptr_q <= ptr_inc;
          default: ;
        endcase
      end
      // read data leaves on falling edges, next byte fetched at each byte start
      if (fall && phase_q == PH_READ) begin
        sdo_en_o  <= 1'b1;
        out_cnt_q <= out_cnt_q + 1'b1;
        if (out_cnt_q == '0) begin
          sdo_o    <= rd_data_i[DW-1];
          out_sr_q <= {rd_data_i[DW-2:0], 1'b0};
        end else begin
          sdo_o    <= out_sr_q[DW-1];
          out_sr_q <= {out_sr_q[DW-2:0], 1'b0};
        end
      end
    end
  end

  assign wr_en_o     = byte_done & ~cs_s_i & (phase_q == PH_WDATA);
  assign wr_data_o   = byte_w;
  assign ptr_o       = ptr_q;
  assign sclk_fall_o = fall;
  assign in_read_o   = (phase_q == PH_READ);
endmodule

// File: rtl/spi_regport.sv
module spi_regport #(
  parameter int            NUM_REGS    = 16,
  parameter int            DW          = 8,
  parameter int            SYNC_STAGES = 2,
  parameter logic [DW-2:0] CHIP_ID     = 7'b1001111,
  localparam int           PW          = $clog2(NUM_REGS)
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   cs_ni,
  input  logic                   sclk_i,
  input  logic                   sdi_i,
  output logic                   sdo_o,
  output logic                   sdo_en_o,
  output logic [NUM_REGS*DW-1:0] regs_o
);
  logic          cs_s, sclk_s, sdi_s;
  logic          wr_en, sclk_fall, in_read;
  logic [DW-1:0] wr_data, rd_data;
  logic [PW-1:0] ptr;

  spi_regport_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({cs_ni, sclk_i, sdi_i}),
    .q_o   ({cs_s, sclk_s, sdi_s})
  );

  spi_regport_frame #(.NUM_REGS(NUM_REGS), .DW(DW), .CHIP_ID(CHIP_ID)) u_frame (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cs_s_i     (cs_s),
    .sclk_s_i   (sclk_s),
    .sdi_s_i    (sdi_s),
    .rd_data_i  (rd_data),
    .wr_en_o    (wr_en),
    .wr_data_o  (wr_data),
    .ptr_o      (ptr),
    .sclk_fall_o(sclk_fall),
    .in_read_o  (in_read),
    .sdo_o      (sdo_o),
    .sdo_en_o   (sdo_en_o)
  );

  spi_regport_regfile #(.NUM_REGS(NUM_REGS), .DW(DW)) u_regs (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_en_i  (wr_en),
    .wr_addr_i(ptr),
    .wr_data_i(wr_data),
    .rd_addr_i(ptr),
    .rd_data_o(rd_data),
    .regs_o   (regs_o)
  );
endmodule

// File: rtl/spi_regport_chk.sv
module spi_regport_chk #(
  parameter int  NUM_REGS = 16,
  localparam int PW       = $clog2(NUM_REGS)
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          cs_s,
  input logic          sclk_fall,
  input logic          wr_en,
  input logic [PW-1:0] ptr,
  input logic          in_read,
  input logic          sdo_o,
  input logic          sdo_en_o
);
  a_r8_off_when_deselected: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_s |=> !sdo_en_o);

  a_r8_drive_only_in_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sdo_en_o |-> in_read);

  a_r6_enable_on_fall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sdo_en_o) |-> $past(sclk_fall));

  a_r6_bit_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sdo_en_o && $past(sdo_en_o) && !$past(sclk_fall)) |-> $stable(sdo_o));

  a_r4_ptr_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en |=> (ptr == (($past(ptr) == PW'(NUM_REGS-1)) ? '0 : $past(ptr) + 1'b1)));
endmodule

bind spi_regport spi_regport_chk #(.NUM_REGS(NUM_REGS)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .cs_s     (cs_s),
  .sclk_fall(sclk_fall),
  .wr_en    (wr_en),
  .ptr      (ptr),
  .in_read  (in_read),
  .sdo_o    (sdo_o),
  .sdo_en_o (sdo_en_o)
);

// File: tb/spi_regport_bench.sv
module spi_regport_bench;
  typedef logic [7:0] bq_t[$];

  logic clk = 1'b0, rst_n = 1'b0;
  logic cs_n = 1'b1, sclk = 1'b0, sdi = 1'b0;
  logic sdo, sdo_en;
  logic [127:0] regs;

  int n_chk = 0, n_fail = 0;
  logic [7:0] m_regs [16];
  int m_ptr = 0;
  logic [7:0] exp_q[$];
  logic oe_seen = 1'b0;
  logic [7:0] mon_sr = '0;
  int mon_cnt = 0;

  always #4 clk = ~clk;

  spi_regport u_spi_regport (
    .clk_i(clk), .rst_ni(rst_n), .cs_ni(cs_n), .sclk_i(sclk), .sdi_i(sdi),
    .sdo_o(sdo), .sdo_en_o(sdo_en), .regs_o(regs)
  );

  task automatic chk(string req, logic [127:0] act, logic [127:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic logic [127:0] model_vec();
    logic [127:0] v;
    for (int i = 0; i < 16; i++) v[i*8 +: 8] = m_regs[i];
    return v;
  endfunction

  function automatic int inc(int p);
    return (p == 15) ? 0 : p + 1;
  endfunction

  always @(negedge clk) if (sdo_en) oe_seen = 1'b1;

  // monitor: host samples on rising serial clock
  always @(posedge sclk) begin
    if (sdo_en) begin
      mon_sr = {mon_sr[6:0], sdo};
      mon_cnt++;
      if (mon_cnt == 8) begin
        mon_cnt = 0;
        if (exp_q.size() == 0) chk("R6 unexpected byte", {120'd0, mon_sr}, 128'hx);
        else chk("R6/R7 read byte", {120'd0, mon_sr}, {120'd0, exp_q.pop_front()});
      end
    end
  end

  task automatic bits(input logic [7:0] tx, input int n);
    for (int i = 7; i > 7 - n; i--) begin
      sdi = tx[i];
      repeat (8) @(negedge clk);
      sclk = 1'b1;
      repeat (8) @(negedge clk);
      sclk = 1'b0;
    end
  endtask

  task automatic sel();
    @(negedge clk);
    cs_n = 1'b0;
    repeat (8) @(negedge clk);
  endtask

  task automatic desel();
    repeat (8) @(negedge clk);
    cs_n = 1'b1;
    repeat (16) @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] addr, input logic [7:0] p, input bq_t d);
    sel();
    bits(addr, 8);
    bits(p, 8);
    if (addr == 8'h9E) m_ptr = (p < 16) ? int'(p) : 0;
    foreach (d[k]) begin
      bits(d[k], 8);
      if (addr == 8'h9E) begin
        m_regs[m_ptr] = d[k];
        m_ptr = inc(m_ptr);
      end
    end
    desel();
  endtask

  task automatic rd(input int n);
    sel();
    for (int k = 0; k < n; k++) begin
      exp_q.push_back(m_regs[m_ptr]);
      m_ptr = inc(m_ptr);
    end
    bits(8'h9F, 8);
    for (int k = 0; k < n; k++) bits(8'h00, 8);
    desel();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog act=running exp=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    for (int i = 0; i < 16; i++) m_regs[i] = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1
    chk("R1 regs after reset", regs, 128'd0);
    chk("R1 enable after reset", {127'd0, sdo_en}, 128'd0);

    // R3 R4: write burst, no output enable during writes (R8)
    oe_seen = 1'b0;
    wr(8'h9E, 8'h02, '{8'hA5, 8'h3C, 8'h7E});
    chk("R3 burst write", regs, model_vec());
    chk("R8 no drive in write", {127'd0, oe_seen}, 128'd0);

    // R7: pointer-only write then read burst
    wr(8'h9E, 8'h02, '{});
    rd(3);
    chk("R8 enable off after read", {127'd0, sdo_en}, 128'd0);
    chk("R6/R7 all bytes returned", exp_q.size(), 0);

    // R4 wrap 15 -> 0
    wr(8'h9E, 8'h0E, '{8'h11, 8'h22, 8'h33});
    chk("R4 wrap write", regs, model_vec());

    // R5 out-of-range pointer selects 0
    wr(8'h9E, 8'h1F, '{8'h99});
    chk("R5 pointer >= 16", regs, model_vec());

    // R2 mismatched write address ignored
    wr(8'h9A, 8'h03, '{8'hFF, 8'hEE});
    chk("R2 wrong address write", regs, model_vec());

    // R2 mismatched read address never drives
    oe_seen = 1'b0;
    sel();
    bits(8'h9D, 8);
    bits(8'h00, 8);
    desel();
    chk("R2 wrong address no drive", {127'd0, oe_seen}, 128'd0);

    // R9 abort mid data byte
    sel();
    bits(8'h9E, 8);
    bits(8'h06, 8);
    bits(8'hC3, 4);
    desel();
    m_ptr = 6;
    chk("R9 partial byte dropped", regs, model_vec());
    rd(1);
    chk("R9 pointer kept after abort", exp_q.size(), 0);
    wr(8'h9E, 8'h07, '{8'h42});
    chk("R9 realigned write", regs, model_vec());

    // R7 read wrap 15 -> 0
    wr(8'h9E, 8'h0F, '{});
    rd(2);
    chk("R7 read wrap done", exp_q.size(), 0);
    chk("R8 idle enable", {127'd0, sdo_en}, 128'd0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule